// File: doc/BRIEF.md
# 48-bit Excess-1024 Floating-Point Adder/Subtractor

This block adds or subtracts two 48-bit floating-point operands and returns a normalized 48-bit result. Each operand carries a sign in bit 47, an 11-bit exponent in bits 46:36 stored with a bias of 1024, and a 36-bit pure fraction in bits 35:0. The fraction has no hidden bit, so the value is (-1)^sign × frac × 2^(exp − 1024), and a normalized fraction has its top bit (bit 35) set.

An operand pair is taken together with an add/subtract select through a valid/ready handshake. The result appears on a registered output one cycle after the pair is accepted and stays there until the consumer takes it. Inside, the operand with the smaller exponent is shifted right to line up with the other, with any bits shifted out dropped. The magnitudes are then added or subtracted according to the effective signs, and the sum is renormalized. Zero, exponent overflow and exponent underflow are each handled by a fixed rule.

Top module: `fp48_addsub`

## Requirements
- R1: Every nonzero result has fraction bit 35 set. An operand whose fraction is not normalized is renormalized in the result (for example 0x400_100000000 + 0 gives 0x3FD_800000000).
- R2: When the exponents differ, the operand with the smaller exponent is shifted right by the exponent difference before the add, and the bits shifted out are discarded. A difference of 36 or more makes that operand contribute nothing.
- R3: With `op_sub` = 1 the sign of operand B is inverted before the add, so the result is A − B. With `op_sub` = 0 the result is A + B.
- R4: A carry out of the 36-bit magnitude sum shifts the fraction right by one place and raises the exponent by one.
- R5: Leading zeros in the magnitude after a subtraction shift the fraction left until bit 35 is 1, and the exponent drops by the shift amount. The result takes the sign of the operand with the larger aligned magnitude.
- R6: A zero magnitude result, from exact cancellation or from two zero operands, is output as all 48 bits clear.
- R7: An operand with an all-zero fraction is treated as zero, whatever its sign and exponent. The result then equals the other operand, renormalized.
- R8: When the carry increment would take the exponent past 2047, the exponent saturates at 2047 and the fraction stays the shifted sum.
- R9: When the left shift would take the exponent below 0, the result is flushed to all zeros. Reaching exactly 0 is kept as a valid result.
- R10: A pair is accepted on a clock edge where `in_valid` and `in_ready` are both 1. Its result is shown with `out_valid` = 1 after that edge. `in_ready` equals (not `out_valid`) or `out_ready`.
- R11: While `out_valid` = 1 and `out_ready` = 0, `out_valid` and `out_res` hold their values.
- R12: Synchronous active-high `rst` clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is offered |
| in_ready | output | 1 | Block can take an operand pair |
| op_a | input | 48 | Operand A {sign, exp[10:0], frac[35:0]} |
| op_b | input | 48 | Operand B, same layout |
| op_sub | input | 1 | 1 selects A − B, 0 selects A + B |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 48 | Normalized result, same layout |

## Verification
The add path is driven with same-sign pairs at equal exponents, where the sum carries out, and at unequal exponents, where the sum does not. This separates the right renormalization from plain alignment. The subtract path is driven with mixed signs in both operand orders and in both `op_sub` senses, so a wrong result sign or a wrong inversion of B shows up at once. Alignment shifts of 35 and 36 places separate truncation of the last bit from a full shift out. Exponents at 2047 and at 0/1 separate saturation, underflow flush and an exact zero exponent. Zero-fraction operands with nonzero exponents and signs show that zero detection looks only at the fraction.

// File: rtl/fp48_pkg.sv
package fp48_pkg;

    parameter int EXP_W  = 11;
    parameter int FRAC_W = 36;
    parameter int WORD_W = 1 + EXP_W + FRAC_W;
    parameter int LZ_W   = $clog2(FRAC_W + 1);

    localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [FRAC_W-1:0] frac;
    } fp48_t;

    // Number of zero bits above the highest set bit; FRAC_W for zero.
    function automatic logic [LZ_W-1:0] lead_zeros(input logic [FRAC_W-1:0] v);
        logic [LZ_W-1:0] n;
        n = LZ_W'(FRAC_W);
        for (int i = 0; i < FRAC_W; i++) begin
            if (v[i]) n = LZ_W'(FRAC_W - 1 - i);
        end
        return n;
    endfunction

endpackage

// File: rtl/fp48_align.sv
module fp48_align
    import fp48_pkg::*;
(
    input  fp48_t              opa,
    input  fp48_t              opb,
    input  logic               sub,
    output logic [EXP_W-1:0]   big_exp,
    output logic [FRAC_W-1:0]  big_mag,
    output logic [FRAC_W-1:0]  small_mag,
    output logic               big_sgn,
    output logic               small_sgn
);
    localparam logic [EXP_W-1:0] SHIFT_LIM = EXP_W'(FRAC_W);

    logic              b_sgn;
    logic              a_zero, b_zero;
    logic [EXP_W-1:0]  ea, eb, diff;
    logic              swap;
    logic [FRAC_W-1:0] small_raw;

    always_comb begin
        b_sgn  = opb.sign ^ sub;
        a_zero = (opa.frac == '0);
        b_zero = (opb.frac == '0);
        // a zero operand takes the other's exponent so it never drives alignment
        ea     = a_zero ? opb.expo : opa.expo;
        eb     = b_zero ? opa.expo : opb.expo;
        swap   = (eb > ea);

        if (swap) begin
            big_exp   = eb;
            big_mag   = opb.frac;
            big_sgn   = b_sgn;
            small_raw = opa.frac;
            small_sgn = opa.sign;
            diff      = eb - ea;
        end else begin
            big_exp   = ea;
            big_mag   = opa.frac;
            big_sgn   = opa.sign;
            small_raw = opb.frac;
            small_sgn = b_sgn;
            diff      = ea - eb;
        end

        small_mag = (diff >= SHIFT_LIM) ? '0 : (small_raw >> diff);
    end

endmodule

// File: rtl/fp48_norm.sv
module fp48_norm
    import fp48_pkg::*;
(
    input  logic [EXP_W-1:0]   big_exp,
    input  logic [FRAC_W-1:0]  big_mag,
    input  logic [FRAC_W-1:0]  small_mag,
    input  logic               big_sgn,
    input  logic               small_sgn,
    output fp48_t              res
);
    logic [FRAC_W:0]   sum;
    logic              sgn;
    logic [LZ_W-1:0]   lz;

    always_comb begin
        if (big_sgn == small_sgn) begin
            sum = {1'b0, big_mag} + {1'b0, small_mag};
            sgn = big_sgn;
        end else if (big_mag >= small_mag) begin
            sum = {1'b0, big_mag - small_mag};
            sgn = big_sgn;
        end else begin
            sum = {1'b0, small_mag - big_mag};
            sgn = small_sgn;
        end

        lz  = lead_zeros(sum[FRAC_W-1:0]);
        res = '0;

        if (sum == '0) begin
            res = '0;
        end else if (sum[FRAC_W]) begin
            res.sign = sgn;
            res.frac = sum[FRAC_W:1];
            res.expo = (big_exp == EXP_MAX) ? EXP_MAX : big_exp + 1'b1;
        end else if ({{(EXP_W-LZ_W+1){1'b0}}, lz} > {1'b0, big_exp}) begin
            res = '0;
        end else begin
            res.sign = sgn;
            res.frac = sum[FRAC_W-1:0] << lz;
            res.expo = big_exp - EXP_W'(lz);
        end
    end

endmodule

// File: rtl/fp48_addsub.sv
module fp48_addsub
    import fp48_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              op_sub,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_res
);
    fp48_t             a_s, b_s, sum_s, res_q;
    logic [EXP_W-1:0]  big_exp;
    logic [FRAC_W-1:0] big_mag, small_mag;
    logic              big_sgn, small_sgn;
    logic              vld_q, accept;

    assign a_s = fp48_t'(op_a);
    assign b_s = fp48_t'(op_b);

    fp48_align u_align (
        .opa       (a_s),
        .opb       (b_s),
        .sub       (op_sub),
        .big_exp   (big_exp),
        .big_mag   (big_mag),
        .small_mag (small_mag),
        .big_sgn   (big_sgn),
        .small_sgn (small_sgn)
    );

    fp48_norm u_norm (
        .big_exp   (big_exp),
        .big_mag   (big_mag),
        .small_mag (small_mag),
        .big_sgn   (big_sgn),
        .small_sgn (small_sgn),
        .res       (sum_s)
    );

    assign in_ready  = !vld_q || out_ready;
    assign accept    = in_valid && in_ready;
    assign out_valid = vld_q;
    assign out_res   = res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            if (accept) begin
                res_q <= sum_s;
                vld_q <= 1'b1;
            end else if (out_ready) begin
                vld_q <= 1'b0;
            end
        end
    end

    // R1
    norm_msb_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_res[FRAC_W-1:0] != '0) |-> out_res[FRAC_W-1]);

    // R6
    zero_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_res[FRAC_W-1:0] == '0) |-> (out_res == '0));

    // R10
    accept_shows_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    // R11
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_res)));

    // R12
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

// File: tb/fp48_addsub_bench.sv
module fp48_addsub_bench;

    localparam int W  = 48;
    localparam int EW = 8 + 1 + 3 * W;
    localparam int NV = 20;

    // {req, sub, a, b, expected}
    localparam logic [EW-1:0] VECS [NV] = '{
        {8'd2, 1'b0, 48'h401_800000000, 48'h400_800000000, 48'h401_C00000000}, // R2 1 + 0.5
        {8'd2, 1'b0, 48'h3FF_800000000, 48'h401_800000000, 48'h401_A00000000}, // R2 B larger exp
        {8'd2, 1'b0, 48'h401_800000000, 48'h3DE_800000000, 48'h401_800000001}, // R2 shift 35
        {8'd2, 1'b0, 48'h401_800000000, 48'h3DD_800000000, 48'h401_800000000}, // R2 shift 36
        {8'd4, 1'b0, 48'h401_800000000, 48'h401_800000000, 48'h402_800000000}, // R4 1 + 1
        {8'd4, 1'b0, 48'h400_C00000000, 48'h400_C00000000, 48'h401_C00000000}, // R4 .75 + .75
        {8'd3, 1'b1, 48'h401_800000000, 48'h400_800000000, 48'h400_800000000}, // R3 1 - 0.5
        {8'd3, 1'b1, 48'h401_800000000, 48'hC01_800000000, 48'h402_800000000}, // R3 1 - (-1)
        {8'd5, 1'b0, 48'h400_800000000, 48'hC01_800000000, 48'hC00_800000000}, // R5 .5 + (-1)
        {8'd5, 1'b1, 48'h400_800000000, 48'h400_C00000000, 48'hBFF_800000000}, // R5 .5 - .75
        {8'd1, 1'b0, 48'h400_100000000, 48'h000_000000000, 48'h3FD_800000000}, // R1 renormalize
        {8'd6, 1'b1, 48'h401_800000000, 48'h401_800000000, 48'h000_000000000}, // R6 cancel
        {8'd6, 1'b0, 48'h000_000000000, 48'h000_000000000, 48'h000_000000000}, // R6 0 + 0
        {8'd7, 1'b0, 48'h555_000000000, 48'h3FF_C00000000, 48'h3FF_C00000000}, // R7 zero A, odd exp
        {8'd7, 1'b0, 48'h3FF_C00000000, 48'hFAB_000000000, 48'h3FF_C00000000}, // R7 zero B, neg
        {8'd7, 1'b0, 48'h800_000000000, 48'h000_000000000, 48'h000_000000000}, // R7 -0 + 0
        {8'd8, 1'b0, 48'h7FF_800000000, 48'h7FF_800000000, 48'h7FF_800000000}, // R8 saturate
        {8'd9, 1'b1, 48'h000_C00000000, 48'h000_800000000, 48'h000_000000000}, // R9 flush
        {8'd9, 1'b1, 48'h001_C00000000, 48'h001_800000000, 48'h000_800000000}, // R9 exp reaches 0
        {8'd1, 1'b0, 48'h000_000000000, 48'h3C0_080000000, 48'h3BC_800000000}  // R1 renormalize B
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         op_sub = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [W-1:0] out_res;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    fp48_addsub u_fp48_addsub (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .op_a      (op_a),
        .op_b      (op_b),
        .op_sub    (op_sub),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_res   (out_res)
    );

    task automatic check(input int req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d: got %h expected %h", req, got, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        check(12, {47'd0, out_valid}, 48'd0);
        check(10, {47'd0, in_ready}, 48'd1);

        // table walk, one pair per cycle
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_sub   = VECS[i][3*W];
            op_a     = VECS[i][3*W-1:2*W];
            op_b     = VECS[i][2*W-1:W];
            in_valid = 1'b1;
            out_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            check(10, {47'd0, out_valid}, 48'd1);
            check(int'(VECS[i][EW-1:3*W+1]), out_res, VECS[i][W-1:0]);
        end

        // R10 drained: no new pair, result consumed
        @(posedge clk);
        @(negedge clk);
        check(10, {47'd0, out_valid}, 48'd0);

        // R11 backpressure
        op_sub = 1'b0; op_a = 48'h401_800000000; op_b = 48'h400_800000000;
        in_valid = 1'b1; out_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        op_a = 48'h401_800000000; op_b = 48'h401_800000000;
        check(10, {47'd0, in_ready}, 48'd0);
        check(11, out_res, 48'h401_C00000000);
        @(posedge clk);
        @(negedge clk);
        check(11, {47'd0, out_valid}, 48'd1);
        check(11, out_res, 48'h401_C00000000);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(10, out_res, 48'h402_800000000);
        check(10, {47'd0, out_valid}, 48'd1);

        // R12 reset while a result is held
        out_ready = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        out_ready = 1'b1;
        check(12, {47'd0, out_valid}, 48'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule